// File: doc/BRIEF.md
# Multi-Link Bunch-Zero Alignment Unit

This unit receives several deserialized front-end links. Each link delivers one 20-bit frame per 80 MHz frame clock, and two consecutive frames form one 40 MHz bunch crossing. Every frame carries the packed samples of three front-end channels. The receive path in front of each link has a latency that varies by tens of nanoseconds. That is enough to shift one link by more than a whole crossing relative to another. To remove the skew, the front end sends a bunch-zero marker on every link in the same crossing, during a quiet gap in the data. The unit measures how many frame cycles each link's marker trails the earliest one. It then reads all links out of per-link delay buffers so that frames sent together leave together.

Each link writes every frame into a circular delay buffer. A marker gatherer records the arrival slot and the relative offset of every link's marker. A small state machine controls the read side:
- `ST_HUNT` shows nothing valid.
- On the first complete marker set it takes transition *start* to `ST_LOCK`, loading the read pointers.
- A second complete set with identical offsets takes transition *confirm* to `ST_ALIGNED`.
- A set with different offsets in `ST_LOCK` takes transition *relock*: it reloads the read pointers and stays in `ST_LOCK`.
- From `ST_ALIGNED`, a set with different offsets takes transition *slip*: it reloads the read pointers and goes back to `ST_LOCK`.
- A marker timeout in any state takes transition *abort* to `ST_HUNT`.

Independently of the state machine, an idle control character on any link latches a per-link sync error. The unit treats an idle as a front-end failure and never as filler.

Top module: `bz_link_aligner`

## Requirements
- R1: While reset is asserted, `out_valid`, `out_aligned`, `out_bz`, `out_phase`, `sync_err`, `tmo_err` and `link_offset` are all zero.
- R2: A marker is a frame with `lnk_ctrl`=1 and frame bits [7:0]=8'h7C. The offset of link i, reported in `link_offset[3i+2:3i]`, is the number of frame cycles its marker arrived after the earliest link's marker.
- R3: After the first complete marker set, `out_valid` is 1. Every valid cycle then shows, on all links, the frames and control bits that the front end sent in one and the same slot.
- R4: `out_bz` is 1 exactly when `out_valid` is 1 and every link outputs a marker. `out_phase` is 0 in that cycle and toggles on every following valid frame, so two frames mark one crossing.
- R5: A frame with `lnk_ctrl`=1 and bits [7:0]=8'hBC (idle) sets `sync_err[i]` for that link only. The bit stays set until reset.
- R6: If, after the first marker of a set, the remaining links' markers do not all arrive within min(`cfg_window`, DEPTH-2) cycles, `tmo_err` is set and stays set until reset. `out_valid` then drops.
- R7: A skew beyond DEPTH-2 frames (6 by default) raises `tmo_err` even when `cfg_window` is larger. Every reported offset is at most DEPTH-2.
- R8: `out_aligned` becomes 1 only after two consecutive marker sets give identical offsets. It drops after a set with different offsets, and returns after the next identical set.
- R9: With `cfg_window`=0, all markers must arrive in the same cycle; otherwise `tmo_err` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock, one frame per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_window | input | WIN_W | Allowed marker spread in frame cycles |
| lnk_frame | input | N_LINKS*20 | Incoming frames, link i in bits [20i+19:20i] |
| lnk_ctrl | input | N_LINKS | Control-character flag per link |
| out_frame | output | N_LINKS*20 | Aligned frames, same packing as the input |
| out_ctrl | output | N_LINKS | Aligned control flags |
| out_valid | output | 1 | Aligned outputs carry data |
| out_phase | output | 1 | Frame position within the crossing, 0 = first |
| out_bz | output | 1 | Common bunch-zero strobe |
| out_aligned | output | 1 | Offsets confirmed over two marker sets |
| link_offset | output | N_LINKS*AW | Measured offset per link |
| sync_err | output | N_LINKS | Sticky idle-character error per link |
| tmo_err | output | 1 | Sticky marker timeout / excess skew |

## Verification
The hardest situation to reach from the ports is the *slip* path. It needs a link whose latency changes while the unit is already in `ST_ALIGNED`. The change must fall between two markers, so that neither the earlier marker nor the later one is split across the change. The bench models each link as a tap into a shared history of transmitted frames. It moves one link's tap in the middle of a marker period. It then checks that status drops after the next marker with the new offsets, and that it recovers one period later.

// File: rtl/bzal_pkg.sv
package bzal_pkg;
    localparam int FRAME_W = 20;
    localparam logic [7:0] CODE_MARK = 8'h7C;
    localparam logic [7:0] CODE_IDLE = 8'hBC;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_LOCK,
        ST_ALIGNED
    } align_state_e;
endpackage

// File: rtl/bzal_lane.sv
module bzal_lane
    import bzal_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      wr_ptr,
    input  logic [AW-1:0]      rd_ptr,
    input  logic               rd_en,
    input  logic [FRAME_W-1:0] in_frame,
    input  logic               in_ctrl,
    output logic               mark_hit,
    output logic [FRAME_W-1:0] q_frame,
    output logic               q_ctrl,
    output logic               sync_err
);
    logic [FRAME_W:0] store_mem [DEPTH];
    logic             idle_hit;

    // control characters are decoded from the low byte
    assign mark_hit = in_ctrl && (in_frame[7:0] == CODE_MARK);
    assign idle_hit = in_ctrl && (in_frame[7:0] == CODE_IDLE);

    always_ff @(posedge clk) begin
        store_mem[wr_ptr] <= {in_ctrl, in_frame};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_frame  <= '0;
            q_ctrl   <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            if (rd_en) begin
                {q_ctrl, q_frame} <= store_mem[rd_ptr];
            end
            if (idle_hit) begin
                sync_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bzal_gather.sv
module bzal_gather #(
    parameter int N  = 3,
    parameter int AW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         hit,
    input  logic [AW-1:0]        wr_ptr,
    input  logic [AW-1:0]        lim,
    output logic                 done,
    output logic                 tmo,
    output logic [N-1:0][AW-1:0] offs,
    output logic [N-1:0][AW-1:0] mptr
);
    logic                 active;
    logic [N-1:0]         seen;
    logic [AW-1:0]        cnt;
    logic [N-1:0][AW-1:0] offs_r, mptr_r;
    logic                 live, all_now;
    logic [AW-1:0]        cur;

    always_comb begin
        live    = active || (|hit);
        cur     = active ? cnt : '0;
        all_now = &(seen | hit);
        offs    = offs_r;
        mptr    = mptr_r;
        for (int i = 0; i < N; i++) begin
            if (hit[i] && !seen[i]) begin
                offs[i] = cur;
                mptr[i] = wr_ptr;
            end
        end
        done = live && all_now;
        tmo  = live && !all_now && (cur >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            seen   <= '0;
            cnt    <= '0;
            offs_r <= '0;
            mptr_r <= '0;
        end else if (done || tmo) begin
            active <= 1'b0;
            seen   <= '0;
            cnt    <= '0;
        end else if (live) begin
            active <= 1'b1;
            seen   <= seen | hit;
            cnt    <= cur + 1'b1;
            offs_r <= offs;
            mptr_r <= mptr;
        end
    end
endmodule

// File: rtl/bzal_ctrl.sv
module bzal_ctrl
    import bzal_pkg::*;
#(
    parameter int N  = 3,
    parameter int AW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic                 tmo,
    input  logic [N-1:0][AW-1:0] offs,
    input  logic [N-1:0][AW-1:0] mptr,
    output logic [AW-1:0]        wr_ptr,
    output logic [N-1:0][AW-1:0] rd_ptr,
    output logic                 rd_en,
    output logic                 out_valid,
    output logic                 out_aligned,
    output logic                 out_phase,
    output logic                 tmo_err,
    output logic [N-1:0][AW-1:0] off_q
);
    align_state_e         state, state_n;
    logic                 load;
    logic                 ph_rd;
    logic [N-1:0][AW-1:0] off_store;

    // next-state: start, confirm, relock, slip, abort
    always_comb begin
        state_n = state;
        load    = 1'b0;
        unique case (state)
            ST_HUNT: begin
                if (done) begin
                    state_n = ST_LOCK;
                    load    = 1'b1;
                end
            end
            ST_LOCK: begin
                if (done) begin
                    if (offs == off_store) begin
                        state_n = ST_ALIGNED;
                    end else begin
                        load = 1'b1;
                    end
                end
            end
            ST_ALIGNED: begin
                if (done && (offs != off_store)) begin
                    state_n = ST_LOCK;
                    load    = 1'b1;
                end
            end
            default: state_n = ST_HUNT;
        endcase
        if (tmo) begin
            state_n = ST_HUNT;
            load    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= state_n;
        end
    end

    assign rd_en = (state != ST_HUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            off_store <= '0;
            ph_rd     <= 1'b0;
        end else begin
            wr_ptr <= wr_ptr + 1'b1;
            ph_rd  <= load ? 1'b0 : !ph_rd;
            if (load) begin
                off_store <= offs;
            end
            for (int i = 0; i < N; i++) begin
                rd_ptr[i] <= load ? mptr[i] : rd_ptr[i] + 1'b1;
            end
        end
    end

    // output process: every flag lines up with the registered lane data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_aligned <= 1'b0;
            out_phase   <= 1'b0;
            tmo_err     <= 1'b0;
            off_q       <= '0;
        end else begin
            out_valid   <= (state != ST_HUNT);
            out_aligned <= (state == ST_ALIGNED);
            out_phase   <= (state != ST_HUNT) && ph_rd;
            tmo_err     <= tmo_err || tmo;
            off_q       <= off_store;
        end
    end
endmodule

// File: rtl/bz_link_aligner.sv
module bz_link_aligner
    import bzal_pkg::*;
#(
    parameter  int N_LINKS  = 3,
    parameter  int DEPTH    = 8,
    parameter  int WIN_W    = 4,
    localparam int AW       = $clog2(DEPTH),
    localparam int MAX_SKEW = DEPTH - 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WIN_W-1:0]           cfg_window,
    input  logic [N_LINKS*FRAME_W-1:0] lnk_frame,
    input  logic [N_LINKS-1:0]         lnk_ctrl,
    output logic [N_LINKS*FRAME_W-1:0] out_frame,
    output logic [N_LINKS-1:0]         out_ctrl,
    output logic                       out_valid,
    output logic                       out_phase,
    output logic                       out_bz,
    output logic                       out_aligned,
    output logic [N_LINKS*AW-1:0]      link_offset,
    output logic [N_LINKS-1:0]         sync_err,
    output logic                       tmo_err
);
    logic [AW-1:0]                    wr_ptr;
    logic [N_LINKS-1:0][AW-1:0]       rd_ptr, offs, mptr, off_q;
    logic                             rd_en, done, tmo;
    logic [N_LINKS-1:0]               hit, q_mark;
    logic [AW-1:0]                    lim;

    // window is clipped to what the delay buffers can absorb
    always_comb begin
        if (cfg_window > WIN_W'(MAX_SKEW)) begin
            lim = AW'(MAX_SKEW);
        end else begin
            lim = cfg_window[AW-1:0];
        end
    end

    for (genvar g = 0; g < N_LINKS; g++) begin : g_lane
        bzal_lane #(.DEPTH(DEPTH)) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ptr   (wr_ptr),
            .rd_ptr   (rd_ptr[g]),
            .rd_en    (rd_en),
            .in_frame (lnk_frame[g*FRAME_W +: FRAME_W]),
            .in_ctrl  (lnk_ctrl[g]),
            .mark_hit (hit[g]),
            .q_frame  (out_frame[g*FRAME_W +: FRAME_W]),
            .q_ctrl   (out_ctrl[g]),
            .sync_err (sync_err[g])
        );
        assign q_mark[g] = out_ctrl[g] && (out_frame[g*FRAME_W +: 8] == CODE_MARK);
        assign link_offset[g*AW +: AW] = off_q[g];
    end

    bzal_gather #(.N(N_LINKS), .AW(AW)) gather_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .wr_ptr (wr_ptr),
        .lim    (lim),
        .done   (done),
        .tmo    (tmo),
        .offs   (offs),
        .mptr   (mptr)
    );

    bzal_ctrl #(.N(N_LINKS), .AW(AW)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .tmo         (tmo),
        .offs        (offs),
        .mptr        (mptr),
        .wr_ptr      (wr_ptr),
        .rd_ptr      (rd_ptr),
        .rd_en       (rd_en),
        .out_valid   (out_valid),
        .out_aligned (out_aligned),
        .out_phase   (out_phase),
        .tmo_err     (tmo_err),
        .off_q       (off_q)
    );

    assign out_bz = out_valid && (&q_mark);
endmodule

// File: rtl/bzal_checker.sv
module bzal_checker #(
    parameter int N_LINKS  = 3,
    parameter int AW       = 3,
    parameter int MAX_SKEW = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  out_valid,
    input logic                  out_phase,
    input logic                  out_bz,
    input logic                  out_aligned,
    input logic [N_LINKS*AW-1:0] link_offset,
    input logic [N_LINKS-1:0]    sync_err,
    input logic                  tmo_err
);
    assert_bz_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_bz |-> !out_phase);

    assert_phase_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !out_bz) |-> (out_phase != $past(out_phase)));

    assert_sync_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync_err & $past(sync_err)) == $past(sync_err)));

    assert_tmo_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tmo_err) |-> tmo_err);

    assert_tmo_drops_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err) |=> !out_valid);

    for (genvar g = 0; g < N_LINKS; g++) begin : g_rng
        assert_offset_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(link_offset[g*AW +: AW]) <= MAX_SKEW));
    end

    assert_aligned_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_aligned |-> out_valid);

    assert_aligned_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_aligned && $past(out_aligned)) |-> $stable(link_offset));
endmodule

bind bz_link_aligner bzal_checker #(
    .N_LINKS  (N_LINKS),
    .AW       (AW),
    .MAX_SKEW (MAX_SKEW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid   (out_valid),
    .out_phase   (out_phase),
    .out_bz      (out_bz),
    .out_aligned (out_aligned),
    .link_offset (link_offset),
    .sync_err    (sync_err),
    .tmo_err     (tmo_err)
);

// File: tb/bz_link_aligner_tb_top.sv
module bz_link_aligner_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NL = 3;
    localparam int FW = 20;
    localparam int AW = 3;
    localparam int PERIOD = 16;
    // per row: d0, d1, d2, window, expect timeout (one nibble each)
    localparam logic [19:0] VEC [8] = '{
        20'h00060, 20'h02560, 20'h31060, 20'h60360,
        20'h03021, 20'h00791, 20'h44400, 20'h01001
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       cfg_window = 4'd6;
    logic [NL*FW-1:0] lnk_frame = '0;
    logic [NL-1:0]    lnk_ctrl = '0;
    logic [NL*FW-1:0] out_frame;
    logic [NL-1:0]    out_ctrl;
    logic             out_valid, out_phase, out_bz, out_aligned, tmo_err;
    logic [NL*AW-1:0] link_offset;
    logic [NL-1:0]    sync_err;

    always #10 clk = ~clk;

    bz_link_aligner #(.N_LINKS(NL), .DEPTH(8), .WIN_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_window(cfg_window),
        .lnk_frame(lnk_frame), .lnk_ctrl(lnk_ctrl),
        .out_frame(out_frame), .out_ctrl(out_ctrl), .out_valid(out_valid),
        .out_phase(out_phase), .out_bz(out_bz), .out_aligned(out_aligned),
        .link_offset(link_offset), .sync_err(sync_err), .tmo_err(tmo_err)
    );

    int          checks = 0;
    int          errors = 0;
    int          k;
    int          d [NL];
    bit          idle_on [NL];
    bit          mute [NL];
    bit          eq_on;
    int          eq_bad, bz_cnt, ph_bad;
    logic        prev_valid, prev_phase;
    logic [FW:0] hist [16];

    function automatic void chk(bit ok, string tag, int act, int exp, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endfunction

    function automatic int off_of(int i);
        return int'(link_offset[i*AW +: AW]);
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic step();
        logic [FW:0] f;
        @(negedge clk);
        if (out_valid) begin
            if (eq_on) begin
                for (int i = 1; i < NL; i++) begin
                    if (out_frame[i*FW +: FW] != out_frame[FW-1:0] || out_ctrl[i] != out_ctrl[0])
                        eq_bad++;
                end
            end
            if (out_bz) begin
                bz_cnt++;
                if (out_phase) ph_bad++;
            end else if (prev_valid && out_phase == prev_phase) begin
                ph_bad++;
            end
        end
        prev_valid = out_valid;
        prev_phase = out_phase;
        for (int j = 15; j > 0; j--) hist[j] = hist[j-1];
        hist[0] = (k % PERIOD == 0) ? {1'b1, 12'(k), 8'h7C} : {1'b0, 20'(k)};
        for (int i = 0; i < NL; i++) begin
            f = hist[d[i]];
            if (mute[i] && f[FW]) f = {1'b0, 20'(k)};
            if (idle_on[i]) f = {1'b1, 12'h000, 8'hBC};
            lnk_ctrl[i] = f[FW];
            lnk_frame[i*FW +: FW] = f[FW-1:0];
        end
        k++;
    endtask

    task automatic run(int n);
        repeat (n) step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        lnk_frame = '0;
        lnk_ctrl = '0;
        k = 0;
        for (int j = 0; j < 16; j++) hist[j] = '0;
        for (int i = 0; i < NL; i++) begin
            idle_on[i] = 1'b0;
            mute[i] = 1'b0;
        end
        eq_bad = 0; bz_cnt = 0; ph_bad = 0;
        prev_valid = 1'b0; prev_phase = 1'b0;
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_aligned && !out_bz && !out_phase, "R1", int'(out_valid), 0, "flags in reset");
        chk(sync_err == '0 && !tmo_err, "R1", int'(sync_err), 0, "errors in reset");
        chk(link_offset == '0, "R1", int'(link_offset), 0, "offsets in reset");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // table walk: skew patterns, windows and timeouts
        for (int v = 0; v < 8; v++) begin
            logic [19:0] e;
            int mn;
            string tag;
            bit exp_t;
            e = VEC[v];
            d[0] = int'(e[19:16]); d[1] = int'(e[15:12]); d[2] = int'(e[11:8]);
            do_reset();
            cfg_window = e[7:4];
            exp_t = e[0];
            eq_on = 1'b1;
            mn = d[0];
            for (int i = 1; i < NL; i++) if (d[i] < mn) mn = d[i];
            case (v)
                4: tag = "R6";
                5: tag = "R7";
                6, 7: tag = "R9";
                default: tag = "R2";
            endcase
            run(12);
            if (!exp_t) begin
                chk(out_valid, "R3", int'(out_valid), 1, "valid after first marker set");
                chk(!out_aligned, "R8", int'(out_aligned), 0, "not aligned after one set");
            end
            run(58);
            chk(tmo_err == exp_t, tag, int'(tmo_err), int'(exp_t), "timeout flag");
            if (!exp_t) begin
                chk(out_aligned, "R8", int'(out_aligned), 1, "aligned after repeated offsets");
                for (int i = 0; i < NL; i++)
                    chk(off_of(i) == d[i] - mn, "R2", off_of(i), d[i] - mn, "link offset");
                chk(eq_bad == 0, "R3", eq_bad, 0, "misaligned valid cycles");
                chk(bz_cnt >= 2, "R4", bz_cnt, 2, "bunch-zero strobes seen");
                chk(ph_bad == 0, "R4", ph_bad, 0, "phase errors");
            end else begin
                chk(!out_aligned, tag, int'(out_aligned), 0, "aligned despite timeout");
            end
        end

        // latency change while aligned: slip then confirm again
        do_reset();
        cfg_window = 4'd6;
        eq_on = 1'b0;
        d[0] = 0; d[1] = 2; d[2] = 4;
        run(70);
        chk(out_aligned, "R8", int'(out_aligned), 1, "aligned before slip");
        d[2] = 1;
        run(20);
        chk(!out_aligned, "R8", int'(out_aligned), 0, "aligned dropped after slip");
        chk(off_of(2) == 1, "R2", off_of(2), 1, "new offset after slip");
        chk(out_valid, "R3", int'(out_valid), 1, "still valid after relock");
        run(16);
        chk(out_aligned, "R8", int'(out_aligned), 1, "aligned again after repeat");
        chk(ph_bad == 0, "R4", ph_bad, 0, "phase across slip");

        // idle character on link 1 only
        do_reset();
        d[0] = 0; d[1] = 0; d[2] = 0;
        run(20);
        idle_on[1] = 1'b1;
        run(1);
        idle_on[1] = 1'b0;
        run(4);
        chk(sync_err == 3'b010, "R5", int'(sync_err), 2, "idle error bits");
        run(30);
        chk(sync_err == 3'b010, "R5", int'(sync_err), 2, "idle error held");
        chk(!tmo_err, "R5", int'(tmo_err), 0, "idle does not cause timeout");

        // link 2 never sends a marker
        do_reset();
        mute[2] = 1'b1;
        run(40);
        chk(tmo_err, "R6", int'(tmo_err), 1, "missing marker timeout");
        chk(!out_valid, "R6", int'(out_valid), 0, "no valid without full set");

        // marker lost while aligned
        do_reset();
        d[0] = 1; d[1] = 0; d[2] = 2;
        run(70);
        chk(out_aligned && !tmo_err, "R8", int'(out_aligned), 1, "aligned before loss");
        mute[2] = 1'b1;
        run(20);
        chk(tmo_err, "R6", int'(tmo_err), 1, "timeout after loss");
        chk(!out_valid && !out_aligned, "R6", int'(out_valid), 0, "valid dropped after loss");

        finish_run();
    end
endmodule